// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped MDIO master for a PHY management bus. Software builds a complete 32-bit Clause 22 management word (start, opcode, PHY address, register address, turnaround and data) and writes it to the command/data register. If the block is enabled, it then sends 32 ones as a preamble, followed by that word exactly as written, most significant bit first. The MDC clock is generated from the system clock by a programmable divider.

For a read, the opcode field selects read. The block releases MDIO from the second turnaround bit onward and clocks in the 16 bits the PHY returns. It places them in the low half of the same register, while the upper half keeps the command. When the frame ends, a sticky completion flag is raised, and software clears it by writing 1 to it. A busy flag shows that a frame is in progress.

Register map (word address on `bus_addr`): 0 is the command/data register. 1 is the clock register, whose divide value N sits in bits 6:1. 2 is the event register, where bit 0 is completion (write 1 to clear) and bit 1 is busy (read-only). 3 is the control register, where bit 0 enables management mode.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, MDC, MDIO out and MDIO output-enable are low, and all four registers read back as zero.
- R2: A started frame drives 32 ones, then the 32 written bits MSB first. MDIO changes only together with an MDC falling edge, and the first bit appears with MDC low on the cycle after the accepting write.
- R3: While a frame runs, MDC is low for N system clocks and then high for N system clocks for each bit, giving a period of 2N clocks. A frame lasts 128·N clocks.
- R4: Output-enable is high for the whole of a frame whose bits 29:28 are not 2'b10. When bits 29:28 are 2'b10 (read), it is high only up to the first turnaround bit (frame bit 46) and low from frame bit 47 to the end.
- R5: In a read frame, MDIO-in is sampled on the 16 MDC rising edges of frame bits 48..63. When the frame completes, the samples land in data register bits 15:0 (first sample in bit 15), and bits 31:16 keep the command.
- R6: Completion sets event bit 0. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R7: Event bit 1 reads 1 exactly while a frame is in progress.
- R8: A write to the data register while a frame is in progress changes neither the register nor the frame.
- R9: The clock register stores all 32 written bits, and only bits 6:1 are used as N.
- R10: When N is 0, MDC stays low and a data-register write starts no frame, although the value is stored.
- R11: When control bit 0 is clear, a data-register write starts no frame, although the value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that the divide value is not rewritten while a frame is in progress, because the MDC timing would then follow the new value in mid-bit. They also assume that a completion-clear write does not fall on the same clock as completion itself. The bench changes the clock register and clears the event only while the busy flag is low.

The PHY stub drives MDIO-in only while output-enable is low, and it changes the value one clock after each MDC rise, so every sampled bit is stable at its rising edge. Read and write frames are run at several divide values. Zero divide and cleared enable are each exercised with a write that should be refused.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + DATA_W;
  localparam int RX_BITS    = 16;
  localparam int OP_MSB     = 29;
  localparam int DIV_W      = 6;
  localparam int DIV_LSB    = 1;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLK  = 2'd1;
  localparam logic [ADDR_W-1:0] A_EVT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             term;

  assign term = run && (cnt_q == (div - {{(DIV_W-1){1'b0}}, 1'b1}));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term && !mdc_q;
  assign fall_tick = term && mdc_q;

  // R3
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !term) |=> $stable(mdc));

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_shift_eng.sv
module mdio_shift_eng
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DATA_W-1:0]  word,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               is_read,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [RX_BITS-1:0] rx_data
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA2_IDX  = BIT_W'(FRAME_BITS - RX_BITS - 1);
  localparam logic [BIT_W-1:0] RX0_IDX  = BIT_W'(FRAME_BITS - RX_BITS);

  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [RX_BITS-1:0]    rx_q, rx_d;

  always_comb begin
    tx_d   = tx_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    rx_d   = rx_q;
    if (start) begin
      tx_d   = {{PRE_BITS{1'b1}}, word};
      bit_d  = '0;
      busy_d = 1'b1;
      rd_d   = (word[OP_MSB -: 2] == OP_READ);
      rx_d   = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (bit_q >= RX0_IDX))
        rx_d = {rx_q[RX_BITS-2:0], mdio_i};
      if (fall_tick) begin
        tx_d = tx_q << 1;
        if (bit_q == LAST_IDX) busy_d = 1'b0;
        else bit_d = bit_q + {{(BIT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      tx_q   <= tx_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign is_read = rd_q;
  assign done    = busy_q && fall_tick && (bit_q == LAST_IDX);
  assign mdio_o  = busy_q && tx_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= TA2_IDX));
  assign rx_data = rx_q;

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mdio_oe && mdio_o && busy));

  // R2
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_tick && !start) |=> $stable(mdio_o));

  // R4
  oe_drop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mdio_oe && !busy));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]          rst_sync_q;
  logic                rst_s;
  logic [DATA_W-1:0]   data_q, data_d;
  logic [DATA_W-1:0]   clk_q, clk_d;
  logic                evt_q, evt_d;
  logic                en_q, en_d;
  logic [DIV_W-1:0]    div;
  logic                busy, is_read, done, start;
  logic                rise_tick, fall_tick;
  logic [RX_BITS-1:0]  rx_data;
  logic                wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign div     = clk_q[DIV_LSB +: DIV_W];
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign start   = wr_data && !busy && en_q && (div != '0);

  always_comb begin
    data_d = data_q;
    clk_d  = clk_q;
    evt_d  = evt_q;
    en_d   = en_q;
    if (wr_data && !busy) data_d = bus_wdata;
    if (done && is_read) data_d[RX_BITS-1:0] = rx_data;
    if (bus_wr && (bus_addr == A_CLK))  clk_d = bus_wdata;
    if (bus_wr && (bus_addr == A_CTRL)) en_d  = bus_wdata[0];
    if (done) evt_d = 1'b1;
    else if (bus_wr && (bus_addr == A_EVT) && bus_wdata[0]) evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      data_q <= '0;
      clk_q  <= '0;
      evt_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      clk_q  <= clk_d;
      evt_q  <= evt_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_CLK:   bus_rdata = clk_q;
      A_EVT:   bus_rdata = {{(DATA_W-2){1'b0}}, busy, evt_q};
      default: bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
    endcase
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (busy),
    .div       (div),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shift_eng u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .word      (bus_wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .is_read   (is_read),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rx_data   (rx_data)
  );

  // R6
  done_sets_evt_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> evt_q);

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && wr_data && !done) |=> $stable(data_q));

  // R10
  zero_div_no_start_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (div == '0 && !busy) |=> !busy);

  // R11
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!en_q && !busy) |=> !busy);
endmodule

// File: tb/tb_mdio_frame_ctrl.sv
module tb_mdio_frame_ctrl;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests, fails;
  bit finished;

  mdio_frame_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model state
  bit          m_busy, m_done, m_en, m_rd;
  int          m_j, m_n;
  logic [31:0] m_word, m_data, m_clk;
  logic [15:0] phy_data;

  always @(posedge clk) begin
    bit b0, fin;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_en = 0; m_rd = 0; m_j = 0; m_n = 0;
      m_word = 0; m_data = 0; m_clk = 0;
    end else begin
      b0 = m_busy; fin = 0;
      if (m_busy) begin
        m_j++;
        if (m_j == 128 * m_n) begin
          m_busy = 0; fin = 1;
          if (m_rd) m_data[15:0] = phy_data;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: if (!b0) begin
            m_data = bus_wdata;
            if (m_en && m_clk[6:1] != 0) begin
              m_busy = 1; m_j = 0; m_word = bus_wdata;
              m_n = m_clk[6:1]; m_rd = (bus_wdata[29:28] == 2'b10);
            end
          end
          2'd1: m_clk = bus_wdata;
          2'd2: if (bus_wdata[0]) m_done = 0;
          default: m_en = bus_wdata[0];
        endcase
      end
      if (fin) m_done = 1;
    end
  end

  // PHY stub: drives read data while the master releases the line
  int  phy_idx;
  logic mdc_prev;
  always @(posedge clk) begin
    mdc_prev <= mdc;
    if (mdio_oe) phy_idx <= 0;
    else if (mdc && !mdc_prev) phy_idx <= phy_idx + 1;
  end
  assign mdio_i = (!mdio_oe && phy_idx >= 1 && phy_idx <= 16) ? phy_data[16 - phy_idx] : 1'b0;

  // per-cycle comparison of the pins
  always @(negedge clk) begin
    int k, ph;
    bit e_mdc, e_o, e_oe;
    if (rst_n && !finished) begin
      if (m_busy) begin
        k = m_j / (2 * m_n); ph = m_j % (2 * m_n);
        e_mdc = (ph >= m_n);
        e_oe  = !(m_rd && k >= 47);
        e_o   = (k < 32) ? 1'b1 : m_word[63 - k];
      end else begin
        e_mdc = 0; e_o = 0; e_oe = 0;
      end
      tests++;
      if (mdc !== e_mdc) begin
        fails++; $display("FAIL R3 mdc t=%0t got %b exp %b", $time, mdc, e_mdc);
      end
      tests++;
      if (mdio_oe !== e_oe) begin
        fails++; $display("FAIL R4 mdio_oe t=%0t got %b exp %b", $time, mdio_oe, e_oe);
      end
      if (e_oe) begin
        tests++;
        if (mdio_o !== e_o) begin
          fails++; $display("FAIL R2 mdio_o t=%0t got %b exp %b", $time, mdio_o, e_o);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    @(negedge clk); bus_addr = a; #2; v = bus_rdata;
    tests++;
    if (v !== exp) begin
      fails++; $display("FAIL %s reg%0d got %h exp %h", req, a, v, exp);
    end
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_rd(input int phy, input int r);
    return 32'h6002_0000 | (32'(phy & 31) << 23) | (32'(r & 31) << 18);
  endfunction
  function automatic logic [31:0] mk_wr(input int phy, input int r, input logic [15:0] v);
    return 32'h5002_0000 | (32'(phy & 31) << 23) | (32'(r & 31) << 18) | 32'(v);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    tests = 0; fails = 0; finished = 0; phy_data = 16'h0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 32'h0, "R1");

    // R9 full clock register stored, N = 1 from bits 6:1
    wr(2'd1, 32'hFFFF_FF83);
    rd_chk(2'd1, 32'hFFFF_FF83, "R9");
    wr(2'd3, 32'h1);
    rd_chk(2'd3, 32'h1, "R11");

    // write frame, N=1 (R2 R3 R4)
    w = mk_wr(5, 3, 16'hBEEF);
    wr(2'd0, w);
    rd_chk(2'd2, 32'h2, "R7");            // busy, no done yet
    wr(2'd0, 32'h1234_5678);              // R8 ignored while busy
    rd_chk(2'd0, w, "R8");
    wait_idle();
    rd_chk(2'd2, 32'h1, "R6");
    rd_chk(2'd0, w, "R8");
    wr(2'd2, 32'h0);
    rd_chk(2'd2, 32'h1, "R6");
    wr(2'd2, 32'h1);
    rd_chk(2'd2, 32'h0, "R6");

    // read frame, N=3 (R4 R5)
    wr(2'd1, 32'h0000_0006);
    phy_data = 16'hA55A;
    w = mk_rd(17, 31);
    wr(2'd0, w);
    rd_chk(2'd2, 32'h2, "R7");
    wait_idle();
    rd_chk(2'd0, {w[31:16], 16'hA55A}, "R5");
    rd_chk(2'd2, 32'h1, "R6");
    wr(2'd2, 32'h1);

    // read frame, N=2, other pattern (R5)
    wr(2'd1, 32'h0000_0004);
    phy_data = 16'h0001;
    w = mk_rd(0, 1);
    wr(2'd0, w);
    wait_idle();
    rd_chk(2'd0, {w[31:16], 16'h0001}, "R5");
    wr(2'd2, 32'h1);

    // R10 zero divide: no frame, value stored
    wr(2'd1, 32'h0000_0081);
    wr(2'd0, mk_wr(1, 2, 16'h00FF));
    repeat (20) @(negedge clk);
    rd_chk(2'd2, 32'h0, "R10");
    rd_chk(2'd0, mk_wr(1, 2, 16'h00FF), "R10");

    // R11 disabled: no frame, value stored
    wr(2'd1, 32'h0000_0002);
    wr(2'd3, 32'h0);
    wr(2'd0, mk_wr(3, 4, 16'h0F0F));
    repeat (20) @(negedge clk);
    rd_chk(2'd2, 32'h0, "R11");
    rd_chk(2'd0, mk_wr(3, 4, 16'h0F0F), "R11");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule